// File: doc/BRIEF.md
# Configuration item streaming port

This block serves a fixed set of read-only configuration items to a host through a small register window. A host first writes a 16-bit key to choose an item, then streams the item out with data reads. Each data read returns the next bytes of the item and moves an internal byte cursor forward. Once the item is used up, reads return zero. Item bytes live in a byte ROM that is set by a parameter. Entry tables, also parameters, give each key a start address and a byte length. There are two banks of entries. Bit 15 of the key chooses the bank: generic or architecture-local.

The `COMBINED` parameter chooses one of two decode variants. In the combined variant, a single port carries both select and data, and the access size tells them apart. In the split variant, the selector and the data register sit at separate addresses, and a data read may return up to `DATA_BYTES` bytes at once. Every request completes in one cycle (`req_ready_o` stays high). Each accepted request produces exactly one response on the following cycle.

Top module: `cfg_item_port`

## Requirements
- R1: After reset, key 0 (bank 0, entry 0) is selected with the byte cursor at 0, so the first data read returns that item from its first byte.
- R2: Every accepted selector write sets the byte cursor to 0, whether the key is valid or not; reselecting an item restarts it from its first byte.
- R3: Key bit 15 chooses the bank (0 generic, 1 architecture-local), key bits 13:0 give the entry index, and key bit 14 is ignored.
- R4: An entry index of `NUM_ENT` or above makes the selection invalid, and every data read then returns zero.
- R5: A data read of N bytes returns the next N item bytes in the low N bytes of `rsp_rdata_o`, with the first byte in the most significant of those positions (bits 8N-1:8N-8), and advances the cursor by N.
- R6: If the item ends partway through an N-byte read, the missing low-order byte positions are zero, and the cursor stops at the item length.
- R7: A read with the cursor at or past the item length, or from an entry of length 0, returns zero and leaves the cursor unchanged.
- R8: Combined variant: the address is ignored. A 1-byte read is a data read, a 1-byte write is a data write, and a 2-byte write is a selector write taking the key from `req_wdata_i[15:0]`. Every other size/direction is rejected with `rsp_err_o`=1 and zero data, and leaves the state unchanged.
- R9: Split variant: the selector is at address 0 and accepts only 2-byte writes. The data register is only at address `DATA_ADDR` and accepts sizes 1 to `DATA_BYTES`. Any other access is rejected as in R8.
- R10: Data writes are accepted (`rsp_err_o`=0, zero data) and change neither the selection nor the cursor.
- R11: `req_ready_o` is always 1, and `rsp_valid_o` is high in the cycle after each accepted request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset within the window |
| req_size_i | input | clog2(DATA_BYTES)+1 | Access size in bytes |
| req_wdata_i | input | 8*DATA_BYTES | Write data; key in bits 15:0 |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 8*DATA_BYTES | Read data, right-aligned and big-endian |
| rsp_err_o | output | 1 | Access rejected |

## Verification
The bench builds two instances that share a 64-byte ROM and the same entry tables with `NUM_ENT`=4. One instance is split with 8-byte data reads and the other is combined. Entry lengths of 0, 1, 2, 3, 4, 9 and 11 bytes make several cases reachable in only a few reads: exact-fit reads, a tail that needs zero padding, and empty items. Index 4 is the first invalid key, which makes the invalid-key path reachable. Keys with bit 14 set check that this bit is ignored.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    ACC_REJECT = 2'd0,
    ACC_SELECT = 2'd1,
    ACC_READ   = 2'd2,
    ACC_IGNORE = 2'd3
  } acc_kind_e;

  localparam int unsigned KEY_W        = 16;
  localparam int unsigned KEY_BANK_BIT = 15;
  localparam int unsigned KEY_IDX_W    = 14;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter bit          COMBINED   = 1'b0,
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_ADDR  = 8,
  parameter int unsigned SZ_W       = 4
) (
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  output acc_kind_e         kind_o
);
  generate
    if (COMBINED) begin : g_comb
      logic unused_addr;
      assign unused_addr = ^addr_i;
      always_comb begin
        if (size_i == SZ_W'(1))                  kind_o = write_i ? ACC_IGNORE : ACC_READ;
        else if (size_i == SZ_W'(2) && write_i)  kind_o = ACC_SELECT;
        else                                     kind_o = ACC_REJECT;
      end
    end else begin : g_split
      always_comb begin
        kind_o = ACC_REJECT;
        if (addr_i == '0) begin
          if (write_i && size_i == SZ_W'(2)) kind_o = ACC_SELECT;
        end else if (addr_i == ADDR_W'(DATA_ADDR)) begin
          if (size_i != '0 && size_i <= SZ_W'(DATA_BYTES))
            kind_o = write_i ? ACC_IGNORE : ACC_READ;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cfgp_cursor.sv
module cfgp_cursor
  import cfgp_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned ROM_AW  = 6,
  parameter int unsigned LEN_W   = 8,
  parameter logic [2*NUM_ENT*ROM_AW-1:0] ENT_BASE = '0,
  parameter logic [2*NUM_ENT*LEN_W-1:0]  ENT_LEN  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_fire_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              adv_fire_i,
  input  logic [LEN_W-1:0]  take_i,
  output logic              cur_ok_o,
  output logic [ROM_AW-1:0] cur_base_o,
  output logic [LEN_W-1:0]  cur_len_o,
  output logic [LEN_W-1:0]  cur_off_o
);
  localparam int unsigned IX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int unsigned EN_W = $clog2(2 * NUM_ENT);

  logic                 bank_q, ok_q;
  logic [IX_W-1:0]      idx_q;
  logic [LEN_W-1:0]     off_q;
  logic [KEY_IDX_W-1:0] k_idx;
  logic                 k_ok;
  logic [EN_W-1:0]      ent;
  logic                 unused_key;

  assign k_idx      = key_i[KEY_IDX_W-1:0];
  assign k_ok       = k_idx < KEY_IDX_W'(NUM_ENT);
  assign unused_key = key_i[KEY_IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      idx_q  <= '0;
      ok_q   <= (NUM_ENT > 0);
      off_q  <= '0;
    end else if (sel_fire_i) begin
      bank_q <= key_i[KEY_BANK_BIT];
      idx_q  <= k_ok ? k_idx[IX_W-1:0] : '0;
      ok_q   <= k_ok;
      off_q  <= '0;
    end else if (adv_fire_i) begin
      off_q  <= off_q + take_i;
    end
  end

  assign ent        = EN_W'(bank_q) * EN_W'(NUM_ENT) + EN_W'(idx_q);
  assign cur_base_o = ENT_BASE[int'(ent)*ROM_AW +: ROM_AW];
  assign cur_len_o  = ENT_LEN[int'(ent)*LEN_W +: LEN_W];
  assign cur_ok_o   = ok_q;
  assign cur_off_o  = off_q;
endmodule

// File: rtl/cfgp_gather.sv
module cfgp_gather #(
  parameter int unsigned ROM_AW     = 6,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned SZ_W       = 4,
  parameter logic [(1<<ROM_AW)*8-1:0] ROM_INIT = '0
) (
  input  logic                    cur_ok_i,
  input  logic [ROM_AW-1:0]       base_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [LEN_W-1:0]        off_i,
  input  logic [SZ_W-1:0]         size_i,
  output logic [DATA_BYTES*8-1:0] rdata_o,
  output logic [LEN_W-1:0]        take_o
);
  localparam int unsigned DW = DATA_BYTES * 8;

  logic [7:0]       lane [DATA_BYTES];
  logic [LEN_W-1:0] avail, want;

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
    logic [ROM_AW-1:0] a;
    assign a       = base_i + ROM_AW'(off_i) + ROM_AW'(k);
    assign lane[k] = ROM_INIT[{a, 3'b000} +: 8];
  end

  always_comb begin
    avail  = (cur_ok_i && off_i < len_i) ? len_i - off_i : '0;
    want   = LEN_W'(size_i);
    take_o = (want < avail) ? want : avail;
  end

  // first item byte lands in the highest of the requested lanes
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (LEN_W'(k) < take_o)
        rdata_o = rdata_o | (DW'(lane[k]) << (8 * (int'(size_i) - 1 - k)));
    end
  end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfgp_pkg::*;
#(
  parameter bit          COMBINED   = 1'b0,
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_ADDR  = 8,
  parameter int unsigned NUM_ENT    = 4,
  parameter int unsigned ROM_AW     = 6,
  parameter int unsigned LEN_W      = 8,
  parameter logic [(1<<ROM_AW)*8-1:0]    ROM_INIT = '0,
  parameter logic [2*NUM_ENT*ROM_AW-1:0] ENT_BASE = '0,
  parameter logic [2*NUM_ENT*LEN_W-1:0]  ENT_LEN  = '0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic                           req_write_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [$clog2(DATA_BYTES):0]    req_size_i,
  input  logic [DATA_BYTES*8-1:0]        req_wdata_i,
  output logic                           rsp_valid_o,
  output logic [DATA_BYTES*8-1:0]        rsp_rdata_o,
  output logic                           rsp_err_o
);
  localparam int unsigned SZ_W = $clog2(DATA_BYTES) + 1;
  localparam int unsigned DW   = DATA_BYTES * 8;

  acc_kind_e         acc_kind;
  logic              sel_fire, adv_fire;
  logic              cur_ok;
  logic [ROM_AW-1:0] cur_base;
  logic [LEN_W-1:0]  cur_len, cur_off, take;
  logic [DW-1:0]     rd_data;
  logic              unused_wdata;

  assign req_ready_o  = 1'b1;
  assign sel_fire     = req_valid_i && (acc_kind == ACC_SELECT);
  assign adv_fire     = req_valid_i && (acc_kind == ACC_READ);
  assign unused_wdata = ^req_wdata_i[DW-1:KEY_W];

  cfgp_decode #(
    .COMBINED(COMBINED), .DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W),
    .DATA_ADDR(DATA_ADDR), .SZ_W(SZ_W)
  ) u_decode (
    .write_i(req_write_i), .addr_i(req_addr_i), .size_i(req_size_i),
    .kind_o(acc_kind)
  );

  cfgp_cursor #(
    .NUM_ENT(NUM_ENT), .ROM_AW(ROM_AW), .LEN_W(LEN_W),
    .ENT_BASE(ENT_BASE), .ENT_LEN(ENT_LEN)
  ) u_cursor (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sel_fire_i(sel_fire), .key_i(req_wdata_i[KEY_W-1:0]),
    .adv_fire_i(adv_fire), .take_i(take),
    .cur_ok_o(cur_ok), .cur_base_o(cur_base),
    .cur_len_o(cur_len), .cur_off_o(cur_off)
  );

  cfgp_gather #(
    .ROM_AW(ROM_AW), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES),
    .SZ_W(SZ_W), .ROM_INIT(ROM_INIT)
  ) u_gather (
    .cur_ok_i(cur_ok), .base_i(cur_base), .len_i(cur_len), .off_i(cur_off),
    .size_i(req_size_i), .rdata_o(rd_data), .take_o(take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= adv_fire ? rd_data : '0;
      rsp_err_o   <= req_valid_i && (acc_kind == ACC_REJECT);
    end
  end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
  import cfgp_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned DW    = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             rsp_valid_o,
  input logic [DW-1:0]    rsp_rdata_o,
  input logic             rsp_err_o,
  input acc_kind_e        kind_i,
  input logic             cur_ok_i,
  input logic [LEN_W-1:0] cur_len_i,
  input logic [LEN_W-1:0] cur_off_i
);
  p_rsp_follows_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_spurious_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_select_clears_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && kind_i == ACC_SELECT) |=> cur_off_i == '0);
  p_invalid_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && kind_i == ACC_READ && !cur_ok_i) |=> rsp_rdata_o == '0);
  p_off_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_ok_i |-> cur_off_i <= cur_len_i);
  p_reject_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && kind_i == ACC_REJECT) |=> (rsp_err_o && rsp_rdata_o == '0));
  p_reject_keeps_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && kind_i == ACC_REJECT) |=> $stable(cur_off_i));
  p_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && kind_i == ACC_IGNORE) |=> ($stable(cur_off_i) && !rsp_err_o));
endmodule

bind cfg_item_port cfgp_checker #(.LEN_W(LEN_W), .DW(DATA_BYTES*8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
  .kind_i(acc_kind), .cur_ok_i(cur_ok), .cur_len_i(cur_len), .cur_off_i(cur_off)
);

// File: tb/cfg_item_port_tb_top.sv
module cfg_item_port_tb_top;
  localparam int NE = 4;
  localparam int AW = 6;
  localparam int LW = 8;

  function automatic logic [7:0] rb(int a);
    return 8'(((a & 63) * 37 + 11) & 255);
  endfunction
  function automatic int tb_base(int e);
    case (e) 0: return 0; 1: return 4; 2: return 16; 3: return 20;
             4: return 32; 5: return 48; 6: return 50; default: return 60; endcase
  endfunction
  function automatic int tb_len(int e);
    case (e) 0: return 4; 1: return 11; 2: return 0; 3: return 3;
             4: return 9; 5: return 2; 6: return 1; default: return 4; endcase
  endfunction
  function automatic logic [511:0] mk_rom();
    logic [511:0] r;
    for (int a = 0; a < 64; a++) r[a*8 +: 8] = rb(a);
    return r;
  endfunction
  function automatic logic [2*NE*AW-1:0] mk_base();
    logic [2*NE*AW-1:0] r;
    for (int e = 0; e < 2*NE; e++) r[e*AW +: AW] = AW'(tb_base(e));
    return r;
  endfunction
  function automatic logic [2*NE*LW-1:0] mk_len();
    logic [2*NE*LW-1:0] r;
    for (int e = 0; e < 2*NE; e++) r[e*LW +: LW] = LW'(tb_len(e));
    return r;
  endfunction

  localparam logic [511:0]         TB_ROM  = mk_rom();
  localparam logic [2*NE*AW-1:0]   TB_BASE = mk_base();
  localparam logic [2*NE*LW-1:0]   TB_LEN  = mk_len();

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        v [2], w [2], rdy [2], rv [2], re [2];
  logic [3:0]  a [2], s [2];
  logic [63:0] wd [2], rd [2];

  cfg_item_port #(.COMBINED(1'b0), .NUM_ENT(NE), .ROM_AW(AW), .LEN_W(LW),
    .ROM_INIT(TB_ROM), .ENT_BASE(TB_BASE), .ENT_LEN(TB_LEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(v[0]), .req_ready_o(rdy[0]),
    .req_write_i(w[0]), .req_addr_i(a[0]), .req_size_i(s[0]), .req_wdata_i(wd[0]),
    .rsp_valid_o(rv[0]), .rsp_rdata_o(rd[0]), .rsp_err_o(re[0]));

  cfg_item_port #(.COMBINED(1'b1), .NUM_ENT(NE), .ROM_AW(AW), .LEN_W(LW),
    .ROM_INIT(TB_ROM), .ENT_BASE(TB_BASE), .ENT_LEN(TB_LEN)) dut_comb (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(v[1]), .req_ready_o(rdy[1]),
    .req_write_i(w[1]), .req_addr_i(a[1]), .req_size_i(s[1]), .req_wdata_i(wd[1]),
    .rsp_valid_o(rv[1]), .rsp_rdata_o(rd[1]), .rsp_err_o(re[1]));

  typedef struct { logic [63:0] d; logic e; string tag; } exp_t;
  exp_t q0[$], q1[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference state per instance: 0 split, 1 combined
  int m_ent [2];
  bit m_ok [2];
  int m_off [2];

  function automatic int kind_of(int u, bit wr, logic [3:0] ad, logic [3:0] sz);
    if (u == 1) begin
      if (sz == 1) return wr ? 3 : 2;
      if (sz == 2 && wr) return 1;
      return 0;
    end
    if (ad == 0) return (wr && sz == 2) ? 1 : 0;
    if (ad == 8 && sz >= 1 && sz <= 8) return wr ? 3 : 2;
    return 0;
  endfunction

  task automatic issue(int u, bit wr, logic [3:0] ad, logic [3:0] sz,
                       logic [63:0] wdat, string tag);
    exp_t x;
    int k, idx, ln, avail, take;
    x.d = '0; x.e = 1'b0; x.tag = tag;
    k = kind_of(u, wr, ad, sz);
    case (k)
      0: x.e = 1'b1;
      1: begin
        idx = int'(wdat[13:0]);
        m_ok[u]  = (idx < NE);
        m_ent[u] = m_ok[u] ? (int'(wdat[15]) * NE + idx) : 0;
        m_off[u] = 0;
      end
      2: begin
        ln    = m_ok[u] ? tb_len(m_ent[u]) : 0;
        avail = (m_off[u] < ln) ? ln - m_off[u] : 0;
        take  = (int'(sz) < avail) ? int'(sz) : avail;
        for (int kk = 0; kk < int'(sz); kk++)
          x.d = (x.d << 8) | ((kk < take) ? 64'(rb(tb_base(m_ent[u]) + m_off[u] + kk)) : 64'd0);
        m_off[u] += take;
      end
      default: ;
    endcase
    if (u == 0) q0.push_back(x); else q1.push_back(x);
    v[u] = 1'b1; w[u] = wr; a[u] = ad; s[u] = sz; wd[u] = wdat;
    @(negedge clk);
    v[u] = 1'b0;
  endtask

  task automatic chk(int u);
    exp_t x;
    if (!rv[u]) return;
    n_checks++;
    if ((u == 0 && q0.size() == 0) || (u == 1 && q1.size() == 0)) begin
      n_fail++;
      $display("FAIL R11 unit %0d: unexpected response d=%h expected none", u, rd[u]);
      return;
    end
    x = (u == 0) ? q0.pop_front() : q1.pop_front();
    if (rd[u] !== x.d || re[u] !== x.e) begin
      n_fail++;
      $display("FAIL %s (unit %0d): got d=%h err=%b expected d=%h err=%b",
               x.tag, u, rd[u], re[u], x.d, x.e);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin chk(0); chk(1); end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog expired: got hang expected completion");
    finish_run();
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      v[u] = 0; w[u] = 0; a[u] = 0; s[u] = 0; wd[u] = 0;
      m_ent[u] = 0; m_ok[u] = 1; m_off[u] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      n_checks++;
      if (rdy[u] !== 1'b1 || rv[u] !== 1'b0) begin
        n_fail++;
        $display("FAIL R11 reset state unit %0d: got rdy=%b rv=%b expected 1 0", u, rdy[u], rv[u]);
      end
    end

    // split variant
    issue(0, 0, 8, 4, 0, "R1 R5 reset selects key 0, 4-byte read");
    issue(0, 0, 8, 1, 0, "R7 read at item end");
    issue(0, 1, 0, 2, 64'h0001, "R2 select entry 1");
    issue(0, 0, 8, 8, 0, "R5 8-byte read");
    issue(0, 0, 8, 8, 0, "R6 tail zero pad");
    issue(0, 0, 8, 2, 0, "R7 exhausted item");
    issue(0, 1, 0, 2, 64'h0001, "R2 reselect");
    issue(0, 0, 8, 2, 0, "R2 cursor restarted");
    issue(0, 1, 0, 2, 64'h8000, "R3 select arch bank");
    issue(0, 0, 8, 3, 0, "R3 arch bank entry 0");
    issue(0, 1, 0, 2, 64'hC001, "R3 select with bit 14");
    issue(0, 0, 8, 2, 0, "R3 bit 14 ignored");
    issue(0, 1, 0, 2, 64'h4003, "R3 select generic with bit 14");
    issue(0, 0, 8, 1, 0, "R3 generic entry 3");
    issue(0, 1, 0, 2, 64'h0004, "R4 select first invalid index");
    issue(0, 0, 8, 4, 0, "R4 invalid key reads zero");
    issue(0, 1, 0, 2, 64'h3FFF, "R4 select top index");
    issue(0, 0, 8, 1, 0, "R4 top index reads zero");
    issue(0, 1, 0, 2, 64'h0002, "R7 select empty item");
    issue(0, 0, 8, 4, 0, "R7 empty item reads zero");
    issue(0, 1, 0, 2, 64'h0003, "R10 select");
    issue(0, 0, 8, 1, 0, "R10 first byte");
    issue(0, 1, 8, 4, 64'hDEADBEEF, "R10 data write accepted");
    issue(0, 0, 8, 1, 0, "R10 cursor unchanged after write");
    issue(0, 1, 0, 4, 64'h0001, "R9 4-byte control write rejected");
    issue(0, 1, 1, 2, 64'h0001, "R9 control write at odd address rejected");
    issue(0, 0, 0, 2, 0, "R9 control read rejected");
    issue(0, 0, 9, 1, 0, "R9 data off-offset rejected");
    issue(0, 0, 8, 0, 0, "R9 zero-size data rejected");
    issue(0, 0, 8, 1, 0, "R9 state untouched by rejects");
    issue(0, 1, 0, 2, 64'h8003, "R5 select arch entry 3");
    issue(0, 0, 8, 4, 0, "R5 exact-fit read at top of ROM");

    // combined variant
    issue(1, 0, 0, 1, 0, "R1 R8 combined reset read");
    issue(1, 0, 5, 1, 0, "R8 address ignored");
    issue(1, 1, 3, 2, 64'h8001, "R8 combined select");
    issue(1, 0, 0, 1, 0, "R8 item byte 0");
    issue(1, 0, 0, 1, 0, "R8 item byte 1");
    issue(1, 0, 0, 1, 0, "R7 combined past end");
    issue(1, 1, 0, 2, 64'h0001, "R8 select entry 1");
    issue(1, 0, 0, 1, 0, "R10 combined first byte");
    issue(1, 1, 0, 1, 64'h00AA, "R10 combined data write");
    issue(1, 0, 0, 1, 0, "R10 combined cursor unchanged");
    issue(1, 0, 0, 2, 0, "R8 2-byte read rejected");
    issue(1, 1, 0, 4, 64'h0003, "R8 4-byte write rejected");
    issue(1, 0, 0, 8, 0, "R8 8-byte read rejected");
    issue(1, 0, 0, 1, 0, "R8 state untouched by rejects");

    repeat (3) @(negedge clk);
    n_checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      n_fail++;
      $display("FAIL R11 missing responses: got %0d/%0d pending expected 0/0", q0.size(), q1.size());
    end
    finish_run();
  end
endmodule